// File: doc/BRIEF.md
# Microcontroller Sleep Sequencer

This block decides when a small microcontroller core sleeps, which clocks keep running while it sleeps, and how it comes back. A sleep instruction reported by the core takes effect only when software has set the sleep-enable input. The two-bit mode select picks one of three depths. The chosen depth sets which peripheral clocks stay on and which interrupt sources may end the sleep.

An enabled and permitted interrupt does not hand control back to the core at once. The core clock stays off through a fixed halt window, and then a one-cycle release pulse starts the vector fetch. A reset request that arrives while the core sleeps or halts ends the sequence at once and asks for a restart from the reset vector instead. On entry to the two lighter depths, the block can issue a single-cycle pulse that starts an ADC conversion.

Top module: `sleep_ctrl`

## Requirements
- R1: A sleep strobe moves the block from awake to sleeping only if `slp_en` is 1 and `rst_req` is 0 in the same cycle. Otherwise the strobe is ignored: the block stays awake and `cpu_clk_en` stays 1.
- R2: `status` reports the state: 00 awake, 01 sleeping, 10 halting. After reset the state is awake, `cpu_clk_en` is 1 and all `per_clk_en` bits are 1.
- R3: `per_clk_en` bits are: [0] timer, [1] ADC, [2] comparator, [3] pin/interrupt logic. They are all 1 when awake or halting. While sleeping they are: mode 00 or 11 → 1111 (bit 2 follows R7); mode 01 → 1010; mode 10 → 0000.
- R4: `irq_req`/`irq_ena` bits are: [0] external level, [1] pin change, [2] timer overflow, [3] comparator, [4] ADC complete, [5] watchdog. In mode 00, and in the reserved mode 11, any of these sources can wake the core.
- R5: In mode 01, only sources 0, 1, 4 and 5 can wake the core. Timer and comparator requests are masked.
- R6: In mode 10, only sources 0, 1 and 5 can wake the core.
- R7: When `acmp_off` is 1, the comparator clock enable is 0 while sleeping in mode 00/11, and a comparator request does not wake the core.
- R8: When sleep is entered in mode 00, 01 or 11 with `adc_on` set, `adc_start` is 1 for exactly the first sleeping cycle. It stays 0 for mode 10 and when `adc_on` is 0.
- R9: A permitted wake moves the block to halting on the next edge. It then spends exactly `HALT_CYC` (4) cycles halting with `cpu_clk_en` 0. After that it returns to awake with `vec_go` high for that one cycle.
- R10: `rst_req` while sleeping or halting returns the block to awake on the next edge with `rst_vec` high for one cycle and no `vec_go`. This happens even when a wake request arrives in the same cycle.
- R11: A source wakes the core only if its `irq_ena` bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slp_en | input | 1 | Sleep permission bit |
| slp_mode | input | 2 | Sleep depth select |
| slp_strobe | input | 1 | Sleep instruction executed |
| rst_req | input | 1 | Reset request from any reset source |
| irq_req | input | 6 | Interrupt requests per source |
| irq_ena | input | 6 | Interrupt enables per source |
| adc_on | input | 1 | ADC is enabled |
| acmp_off | input | 1 | Comparator power-down control |
| cpu_clk_en | output | 1 | Core clock enable |
| per_clk_en | output | 4 | Peripheral clock enables |
| adc_start | output | 1 | Automatic conversion start pulse |
| vec_go | output | 1 | Release to interrupt vector fetch |
| rst_vec | output | 1 | Restart from reset vector |
| status | output | 2 | Current state |

## Verification
A reset request and a permitted interrupt can arrive in the same sleeping cycle. Likewise, a reset request can land inside the halt window just before the release. Both collisions are provoked by directed sequences and also occur in the random phase, where reset requests are sparse and interrupt requests are dense. The judgement is that `rst_vec` fires, the block goes straight to awake and `vec_go` never appears. A sleep strobe that coincides with a reset request is judged in the same way: it must leave the block awake.

// File: rtl/sleep_pkg.sv
package sleep_pkg;

    localparam int NSRC = 6;
    localparam int NPER = 4;

    localparam int SRC_EXT  = 0;
    localparam int SRC_PIN  = 1;
    localparam int SRC_TMR  = 2;
    localparam int SRC_ACMP = 3;
    localparam int SRC_ADC  = 4;
    localparam int SRC_WDT  = 5;

    localparam int PER_TMR  = 0;
    localparam int PER_ADC  = 1;
    localparam int PER_ACMP = 2;
    localparam int PER_PIN  = 3;

    typedef enum logic [1:0] {
        MD_IDLE  = 2'b00,
        MD_QUIET = 2'b01,
        MD_DEEP  = 2'b10,
        MD_RSVD  = 2'b11
    } mode_e;

    typedef enum logic [1:0] {
        ST_AWAKE = 2'b00,
        ST_SLEEP = 2'b01,
        ST_HALT  = 2'b10
    } state_e;

    typedef logic [NSRC-1:0] src_vec_t;
    typedef logic [NPER-1:0] per_vec_t;

    typedef struct packed {
        logic adc_start;
        logic vec_go;
        logic rst_vec;
    } pulse_t;

    // Sources allowed to end sleep in a given depth.
    function automatic src_vec_t wake_allowed(mode_e m, logic acmp_off);
        src_vec_t v;
        v = '0;
        v[SRC_EXT] = 1'b1;
        v[SRC_PIN] = 1'b1;
        v[SRC_WDT] = 1'b1;
        case (m)
            MD_QUIET: v[SRC_ADC] = 1'b1;
            MD_DEEP:  v = v;
            default: begin
                v[SRC_ADC]  = 1'b1;
                v[SRC_TMR]  = 1'b1;
                v[SRC_ACMP] = !acmp_off;
            end
        endcase
        return v;
    endfunction

    // Peripheral clocks kept running while asleep in a given depth.
    function automatic per_vec_t per_running(mode_e m, logic acmp_off);
        per_vec_t p;
        p = '0;
        case (m)
            MD_QUIET: begin
                p[PER_ADC] = 1'b1;
                p[PER_PIN] = 1'b1;
            end
            MD_DEEP: p = '0;
            default: begin
                p           = '1;
                p[PER_ACMP] = !acmp_off;
            end
        endcase
        return p;
    endfunction

    function automatic logic adc_autostart(mode_e m);
        return m != MD_DEEP;
    endfunction

endpackage

// File: rtl/wake_filter.sv
module wake_filter
    import sleep_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  src_vec_t req,
    input  src_vec_t ena,
    input  mode_e    mode,
    input  logic     acmp_off,
    output src_vec_t hit
);

    src_vec_t allow;

    always_comb allow = wake_allowed(mode, acmp_off);

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        assign hit[i] = req[i] & ena[i] & allow[i];
    end

    AST_QUIET_MASK: assert property (@(posedge clk) disable iff (rst)
        (mode == MD_QUIET) |-> !(hit[SRC_TMR] || hit[SRC_ACMP]))
        else $error("quiet mode let a masked source through"); // R5

    AST_DEEP_MASK: assert property (@(posedge clk) disable iff (rst)
        (mode == MD_DEEP) |-> !(hit[SRC_TMR] || hit[SRC_ACMP] || hit[SRC_ADC]))
        else $error("deep mode let a masked source through"); // R6

endmodule

// File: rtl/halt_timer.sv
module halt_timer #(
    parameter int HALT_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic done
);

    localparam int CW = (HALT_CYC > 2) ? $clog2(HALT_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALT_CYC - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) cnt <= '0;
        else             cnt <= cnt + 1'b1;
    end

    assign done = run && (cnt == LAST);

    AST_HALT_COUNT: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run) && !$past(done)) |-> (cnt == $past(cnt) + 1'b1))
        else $error("halt counter skipped"); // R9

endmodule

// File: rtl/clk_gate.sv
module clk_gate
    import sleep_pkg::*;
(
    input  state_e   state,
    input  mode_e    mode,
    input  logic     acmp_off,
    output logic     cpu_en,
    output per_vec_t per_en
);

    always_comb begin
        cpu_en = (state == ST_AWAKE);
        per_en = (state == ST_SLEEP) ? per_running(mode, acmp_off) : '1;
    end

endmodule

// File: rtl/sleep_ctrl.sv
module sleep_ctrl
    import sleep_pkg::*;
#(
    parameter int HALT_CYC = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            slp_en,
    input  logic [1:0]      slp_mode,
    input  logic            slp_strobe,
    input  logic            rst_req,
    input  logic [NSRC-1:0] irq_req,
    input  logic [NSRC-1:0] irq_ena,
    input  logic            adc_on,
    input  logic            acmp_off,
    output logic            cpu_clk_en,
    output logic [NPER-1:0] per_clk_en,
    output logic            adc_start,
    output logic            vec_go,
    output logic            rst_vec,
    output logic [1:0]      status
);

    state_e   state;
    mode_e    mode_q;
    mode_e    mode_in;
    pulse_t   pulse;
    src_vec_t hit;
    logic     halt_done;
    logic     enter;

    assign mode_in = mode_e'(slp_mode);
    assign enter   = slp_strobe && slp_en && !rst_req;

    wake_filter u_filter (
        .clk      (clk),
        .rst      (rst),
        .req      (irq_req),
        .ena      (irq_ena),
        .mode     (mode_q),
        .acmp_off (acmp_off),
        .hit      (hit)
    );

    halt_timer #(.HALT_CYC(HALT_CYC)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .run  (state == ST_HALT),
        .done (halt_done)
    );

    clk_gate u_gate (
        .state    (state),
        .mode     (mode_q),
        .acmp_off (acmp_off),
        .cpu_en   (cpu_clk_en),
        .per_en   (per_clk_en)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_AWAKE;
            mode_q <= MD_IDLE;
            pulse  <= '0;
        end else begin
            pulse <= '0;
            case (state)
                ST_AWAKE: begin
                    if (enter) begin
                        state           <= ST_SLEEP;
                        mode_q          <= mode_in;
                        pulse.adc_start <= adc_on && adc_autostart(mode_in);
                    end
                end
                ST_SLEEP: begin
                    if (rst_req) begin
                        state         <= ST_AWAKE;
                        pulse.rst_vec <= 1'b1;
                    end else if (|hit) begin
                        state <= ST_HALT;
                    end
                end
                ST_HALT: begin
                    if (rst_req) begin
                        state         <= ST_AWAKE;
                        pulse.rst_vec <= 1'b1;
                    end else if (halt_done) begin
                        state        <= ST_AWAKE;
                        pulse.vec_go <= 1'b1;
                    end
                end
                default: state <= ST_AWAKE;
            endcase
        end
    end

    assign adc_start = pulse.adc_start;
    assign vec_go    = pulse.vec_go;
    assign rst_vec   = pulse.rst_vec;
    assign status    = state;

    AST_STROBE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (state == ST_AWAKE && slp_strobe && !slp_en) |=> (state == ST_AWAKE))
        else $error("sleep entered without permission"); // R1

    AST_ADC_KICK: assert property (@(posedge clk) disable iff (rst)
        adc_start |-> (state == ST_SLEEP && $past(state) == ST_AWAKE))
        else $error("conversion start outside sleep entry"); // R8

    AST_RESET_WINS: assert property (@(posedge clk) disable iff (rst)
        (state != ST_AWAKE && rst_req) |=> (state == ST_AWAKE && rst_vec && !vec_go))
        else $error("reset request did not end sleep"); // R10

    AST_VEC_AFTER_HALT: assert property (@(posedge clk) disable iff (rst)
        vec_go |-> ($past(state) == ST_HALT && cpu_clk_en))
        else $error("vector release without halt"); // R9

    AST_DEEP_GATED: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SLEEP && mode_q == MD_DEEP) |-> (per_clk_en == '0))
        else $error("deep sleep left a clock running"); // R3

endmodule

// File: tb/sleep_ctrl_test.sv
`timescale 1ns/1ps
module sleep_ctrl_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       slp_en = 1'b0;
    logic [1:0] slp_mode = 2'b00;
    logic       slp_strobe = 1'b0;
    logic       rst_req = 1'b0;
    logic [5:0] irq_req = '0;
    logic [5:0] irq_ena = '0;
    logic       adc_on = 1'b0;
    logic       acmp_off = 1'b0;
    logic       cpu_clk_en;
    logic [3:0] per_clk_en;
    logic       adc_start;
    logic       vec_go;
    logic       rst_vec;
    logic [1:0] status;

    int compared = 0;
    int mismatched = 0;
    bit finished = 1'b0;

    // reference model state
    logic [1:0] m_state = 2'b00;
    logic [1:0] m_mode = 2'b00;
    int         m_cnt = 0;
    logic       m_adc = 1'b0;
    logic       m_vec = 1'b0;
    logic       m_rst = 1'b0;

    always #4 clk = ~clk;

    sleep_ctrl uut (
        .clk(clk), .rst(rst), .slp_en(slp_en), .slp_mode(slp_mode),
        .slp_strobe(slp_strobe), .rst_req(rst_req), .irq_req(irq_req),
        .irq_ena(irq_ena), .adc_on(adc_on), .acmp_off(acmp_off),
        .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .adc_start(adc_start),
        .vec_go(vec_go), .rst_vec(rst_vec), .status(status)
    );

    // R4 R5 R6 R7: sources able to wake per depth
    function automatic logic [5:0] exp_allow(logic [1:0] md, logic aoff);
        case (md)
            2'b01:   return 6'b110011;
            2'b10:   return 6'b100011;
            default: return aoff ? 6'b110111 : 6'b111111;
        endcase
    endfunction

    // R3 R7: peripheral clocks per depth
    function automatic logic [3:0] exp_per(logic [1:0] st, logic [1:0] md, logic aoff);
        if (st != 2'b01) return 4'b1111;
        case (md)
            2'b01:   return 4'b1010;
            2'b10:   return 4'b0000;
            default: return aoff ? 4'b1011 : 4'b1111;
        endcase
    endfunction

    task automatic model_edge();
        logic na, nv, nr;
        na = 1'b0; nv = 1'b0; nr = 1'b0;
        if (rst) begin
            m_state = 2'b00; m_mode = 2'b00; m_cnt = 0;
        end else begin
            case (m_state)
                2'b00: if (slp_strobe && slp_en && !rst_req) begin
                    m_state = 2'b01; m_mode = slp_mode;
                    na = adc_on && (slp_mode != 2'b10);
                end
                2'b01: if (rst_req) begin
                    m_state = 2'b00; nr = 1'b1;
                end else if (|(irq_req & irq_ena & exp_allow(m_mode, acmp_off))) begin
                    m_state = 2'b10; m_cnt = 0;
                end
                default: if (rst_req) begin
                    m_state = 2'b00; nr = 1'b1;
                end else if (m_cnt == 3) begin
                    m_state = 2'b00; nv = 1'b1;
                end else begin
                    m_cnt = m_cnt + 1;
                end
            endcase
        end
        m_adc = na; m_vec = nv; m_rst = nr;
    endtask

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all(string ctx);
        chk({"R2 status ", ctx}, {6'b0, status}, {6'b0, m_state});
        chk({"R9 cpu_clk_en ", ctx}, {7'b0, cpu_clk_en}, {7'b0, m_state == 2'b00});
        chk({"R3 per_clk_en ", ctx}, {4'b0, per_clk_en}, {4'b0, exp_per(m_state, m_mode, acmp_off)});
        chk({"R8 adc_start ", ctx}, {7'b0, adc_start}, {7'b0, m_adc});
        chk({"R9 vec_go ", ctx}, {7'b0, vec_go}, {7'b0, m_vec});
        chk({"R10 rst_vec ", ctx}, {7'b0, rst_vec}, {7'b0, m_rst});
    endtask

    task automatic step(string ctx, int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            model_edge();
            @(negedge clk);
            compare_all(ctx);
        end
    endtask

    task automatic quiet();
        slp_strobe = 1'b0; rst_req = 1'b0; irq_req = '0;
    endtask

    task automatic go_sleep(logic [1:0] md, string ctx);
        quiet();
        slp_en = 1'b1; slp_mode = md; slp_strobe = 1'b1;
        step(ctx);
        slp_strobe = 1'b0;
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        @(negedge clk);
        step("reset", 3);
        rst = 1'b0;
        step("R2 after reset");

        // R1: strobe without permission is ignored
        slp_en = 1'b0; slp_strobe = 1'b1;
        step("R1 no enable", 2);
        // R1: strobe with a reset request is ignored
        slp_en = 1'b1; rst_req = 1'b1;
        step("R1 with reset");
        quiet();

        // R4 R8 R9: idle, ADC on, timer wake, halt then release
        adc_on = 1'b1; irq_ena = 6'b111111;
        go_sleep(2'b00, "R8 idle entry");
        step("R4 idle sleeping", 2);
        irq_req[2] = 1'b1;
        step("R4 timer wake");
        irq_req = '0;
        step("R9 halt window", 5);

        // R5 R11: quiet mode masks timer; disabled ADC source ignored
        go_sleep(2'b01, "R5 quiet entry");
        irq_req = 6'b001100;
        step("R5 timer/comparator masked", 3);
        irq_ena = 6'b101111; irq_req = 6'b010000;
        step("R11 disabled source", 3);
        irq_ena = 6'b111111;
        step("R5 adc wake", 6);
        quiet();

        // R6: deep mode, ADC off, only pin change wakes
        adc_on = 1'b0;
        go_sleep(2'b10, "R6 deep entry");
        irq_req = 6'b011100;
        step("R6 masked sources", 3);
        irq_req = 6'b000010;
        step("R6 pin wake", 6);
        quiet();

        // R7: comparator disabled in idle
        acmp_off = 1'b1; adc_on = 1'b1;
        go_sleep(2'b00, "R7 entry");
        irq_req = 6'b001000;
        step("R7 comparator ignored", 3);
        acmp_off = 1'b0;
        step("R7 comparator wakes", 6);
        quiet();

        // R10: reset and wake collide while sleeping, and inside halt
        go_sleep(2'b11, "R4 reserved mode entry");
        irq_req = 6'b000001; rst_req = 1'b1;
        step("R10 collision");
        quiet();
        go_sleep(2'b11, "R4 reserved mode");
        irq_req = 6'b000100;
        step("R4 reserved timer wake");
        irq_req = '0;
        step("R9 halt", 3);
        rst_req = 1'b1;
        step("R10 reset in halt");
        quiet();
        step("R10 settle", 2);

        // random phase
        for (int k = 0; k < 4000; k++) begin
            slp_strobe = ($urandom % 4) == 0;
            slp_en     = ($urandom % 4) != 0;
            slp_mode   = 2'($urandom);
            rst_req    = ($urandom % 40) == 0;
            irq_req    = 6'($urandom & $urandom & $urandom);
            irq_ena    = 6'($urandom);
            adc_on     = 1'($urandom);
            acmp_off   = 1'($urandom);
            step("random R4 R5 R6 R11");
        end

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule